// File: doc/BRIEF.md
# Dual-Section Ripple Binary Counter

This block is a four-stage binary counter split into two sections with no link between them. A single toggle stage divides its own count input by two. A three-stage section divides a second count input by eight. Each section advances on a falling edge of its own count input. A shared clear zeroes all four stages, but only while both clear inputs are high together. Tying the divide-by-two output to the second count input outside the block gives a full 4-bit count of 0 to 15.

The block sits in a synchronous fabric driven by one system clock. Both count inputs and both clear inputs pass through a short synchronizer chain, and falling edges are detected in the clock domain. Inside the upper section, each stage toggles one clock after the stage below it drops from 1 to 0. The ripple of the discrete part is therefore kept as a fixed, countable one-cycle step per stage.

Use the block as a cascaded 4-bit counter, or as a 3-bit counter plus a free toggle stage that shares the clear.

Top module: `dual_ripple_counter`

## Requirements
- R1: Each falling edge of `tick_a_i` inverts `div2_o`. Edges on `tick_a_i` never change `div8_o`.
- R2: Each falling edge of `tick_b_i` steps `div8_o` up by one as a binary value, with bit 0 the least significant. After 7 it wraps to 0. Edges on `tick_b_i` never change `div2_o`.
- R3: Inside the upper section, stage k (k ≥ 1) toggles exactly one clock cycle after stage k-1 goes from 1 to 0, and at no other time.
- R4: The clear acts only while `clr_x_i` and `clr_y_i` are both high. Either one alone leaves every output unchanged.
- R5: While both clear inputs are high, all outputs stay at 0, whatever edges arrive on either count input.
- R6: After the clear is released, the first falling edge on `tick_a_i` sets `div2_o` to 1. The first falling edge on `tick_b_i` sets `div8_o` to 3'b001.
- R7: With `div2_o` fed back into `tick_b_i` and pulses applied to `tick_a_i`, {`div8_o`,`div2_o`} steps from 0 through 15 and wraps to 0. Bit k toggles once every 2^k input pulses, which divides the input by 2^(k+1).
- R8: A rising edge on either count input, or a steady level, leaves the outputs unchanged.
- R9: `rst` is a synchronous active-high reset. One clock edge with `rst` high zeroes all outputs.
- R10: A falling edge on a count input changes the first stage of its section on the (SYNC_STAGES+1)-th rising clock edge after the input is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a_i | input | 1 | Count input of the divide-by-two section |
| tick_b_i | input | 1 | Count input of the divide-by-eight section |
| clr_x_i | input | 1 | First clear input (ANDed with the second) |
| clr_y_i | input | 1 | Second clear input (ANDed with the first) |
| div2_o | output | 1 | Divide-by-two stage output |
| div8_o | output | HI_STAGES | Upper section count, bit 0 least significant |

## Verification
The bench builds the block with SYNC_STAGES = 2 and HI_STAGES = 3, the default divide-by-eight upper section. The short synchronizer makes the input-to-output latency of three clock edges and the one-cycle ripple step per stage easy to sample exactly. Three upper stages keep the complete cascaded 16-state cycle, the 7-to-0 wrap and the per-bit division ratios within a few hundred cycles. These settings also allow clear-gating and clear-override scenarios to be set up from non-zero counts.

// File: rtl/rip_cnt_pkg.sv
package rip_cnt_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_HI_STAGES   = 3;

  typedef struct packed {
    logic level;
    logic fell;
  } samp_t;
endpackage

// File: rtl/rip_in_sampler.sv
module rip_in_sampler
  import rip_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  output samp_t smp_o
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[SYNC_STAGES-1];
  end

  assign smp_o.level = chain[SYNC_STAGES-1];
  assign smp_o.fell  = last & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/rip_toggle_stage.sv
module rip_toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic q_o,
  output logic fell_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_o    <= 1'b0;
      fell_o <= 1'b0;
    end else begin
      fell_o <= tick & q_o;
      if (tick) q_o <= ~q_o;
    end
  end
endmodule

// File: rtl/rip_upper_section.sv
module rip_upper_section #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES:0] tk;
  logic            top_carry_unused;

  assign tk[0] = tick;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      rip_toggle_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .tick   (tk[g]),
        .q_o    (q_o[g]),
        .fell_o (tk[g+1])
      );
    end
  endgenerate

  assign top_carry_unused = tk[STAGES];
endmodule

// File: rtl/dual_ripple_counter.sv
module dual_ripple_counter
  import rip_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned HI_STAGES   = DEF_HI_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_a_i,
  input  logic                 tick_b_i,
  input  logic                 clr_x_i,
  input  logic                 clr_y_i,
  output logic                 div2_o,
  output logic [HI_STAGES-1:0] div8_o
);
  samp_t s_a, s_b, s_x, s_y;
  logic  clr_w;
  logic  a_fell;
  logic  a_level_unused, b_level_unused, x_fell_unused, y_fell_unused;
  logic  a_carry_unused;

  rip_in_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp_a (.clk(clk), .rst(rst), .din(tick_a_i), .smp_o(s_a));
  rip_in_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp_b (.clk(clk), .rst(rst), .din(tick_b_i), .smp_o(s_b));
  rip_in_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp_x (.clk(clk), .rst(rst), .din(clr_x_i),  .smp_o(s_x));
  rip_in_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp_y (.clk(clk), .rst(rst), .din(clr_y_i),  .smp_o(s_y));

  // Clear needs both inputs high together
  assign clr_w  = s_x.level & s_y.level;
  assign a_fell = s_a.fell;

  assign a_level_unused = s_a.level;
  assign b_level_unused = s_b.level;
  assign x_fell_unused  = s_x.fell;
  assign y_fell_unused  = s_y.fell;

  rip_toggle_stage u_low (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_w),
    .tick   (a_fell),
    .q_o    (div2_o),
    .fell_o (a_carry_unused)
  );

  rip_upper_section #(.STAGES(HI_STAGES)) u_high (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_w),
    .tick (s_b.fell),
    .q_o  (div8_o)
  );
endmodule

// File: rtl/dual_ripple_counter_chk.sv
module dual_ripple_counter_chk #(
  parameter int unsigned HI_STAGES = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr,
  input logic                 fell_a,
  input logic                 div2,
  input logic [HI_STAGES-1:0] div8
);
  p_rst_zero_r9: assert property (@(posedge clk)
    rst |=> (div2 == 1'b0 && div8 == '0))
    else $error("p_rst_zero_r9");

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div2 == 1'b0 && div8 == '0))
    else $error("p_clear_zero_r5");

  p_toggle_a_r1: assert property (@(posedge clk) disable iff (rst)
    (!clr && fell_a) |=> (div2 != $past(div2)))
    else $error("p_toggle_a_r1");

  p_hold_a_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !fell_a) |=> $stable(div2))
    else $error("p_hold_a_r8");

  genvar k;
  generate
    for (k = 1; k < HI_STAGES; k++) begin : g_rip
      p_ripple_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && (div8[k] != $past(div8[k])))
          |-> ($past(div8[k-1], 2) && !$past(div8[k-1])))
        else $error("p_ripple_r3");
    end
  endgenerate
endmodule

bind dual_ripple_counter dual_ripple_counter_chk #(.HI_STAGES(HI_STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr    (clr_w),
  .fell_a (a_fell),
  .div2   (div2_o),
  .div8   (div8_o)
);

// File: tb/dual_ripple_counter_bench.sv
`timescale 1ns/1ps
module dual_ripple_counter_bench;
  localparam int unsigned SYNC   = 2;
  localparam int unsigned HI     = 3;
  localparam int unsigned SETTLE = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_a = 1'b0;
  logic          tick_b_drv = 1'b0;
  logic          cascade = 1'b0;
  logic          clr_x = 1'b0;
  logic          clr_y = 1'b0;
  logic          div2_o;
  logic [HI-1:0] div8_o;
  logic          tick_b_w;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  assign tick_b_w = cascade ? div2_o : tick_b_drv;

  dual_ripple_counter #(.SYNC_STAGES(SYNC), .HI_STAGES(HI)) u_dual_ripple_counter (
    .clk(clk), .rst(rst), .tick_a_i(tick_a), .tick_b_i(tick_b_w),
    .clr_x_i(clr_x), .clr_y_i(clr_y), .div2_o(div2_o), .div8_o(div8_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk) tick_a = 1'b1;
    repeat (3) @(negedge clk);
    tick_a = 1'b0;
    settle();
  endtask

  task automatic pulse_b();
    @(negedge clk) tick_b_drv = 1'b1;
    repeat (3) @(negedge clk);
    tick_b_drv = 1'b0;
    settle();
  endtask

  task automatic do_clear();
    @(negedge clk) begin clr_x = 1'b1; clr_y = 1'b1; end
    settle();
    clr_x = 1'b0; clr_y = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R9 div2 after reset", int'(div2_o), 0);
    chk("R9 div8 after reset", int'(div8_o), 0);
    rst = 1'b0;
    settle();
  endtask

  task automatic t_latency();
    @(negedge clk) tick_a = 1'b1;
    repeat (4) @(negedge clk);
    tick_a = 1'b0;
    repeat (SYNC) @(posedge clk);
    #1 chk("R10 div2 before latency", int'(div2_o), 0);
    @(posedge clk);
    #1 chk("R10 div2 at latency", int'(div2_o), 1);
    settle();
  endtask

  task automatic t_rise_ignored();
    @(negedge clk) begin tick_a = 1'b1; tick_b_drv = 1'b1; end
    settle();
    chk("R8 div2 after rise", int'(div2_o), 1);
    chk("R8 div8 after rise", int'(div8_o), 0);
    @(negedge clk) begin tick_a = 1'b0; tick_b_drv = 1'b0; end
    settle();
  endtask

  task automatic t_div2();
    do_clear();
    for (int i = 1; i <= 4; i++) begin
      pulse_a();
      chk("R1 div2 toggle", int'(div2_o), i % 2);
      chk("R1 div8 untouched", int'(div8_o), 0);
    end
  endtask

  task automatic t_upper();
    do_clear();
    for (int i = 1; i <= 9; i++) begin
      pulse_b();
      chk("R2 div8 count", int'(div8_o), i % 8);
      chk("R2 div2 untouched", int'(div2_o), 0);
    end
  endtask

  task automatic t_ripple();
    do_clear();
    pulse_b();
    chk("R3 setup", int'(div8_o), 1);
    @(negedge clk) tick_b_drv = 1'b1;
    repeat (3) @(negedge clk);
    tick_b_drv = 1'b0;
    repeat (SYNC + 1) @(posedge clk);
    #1 chk("R3 stage0 fell first", int'(div8_o), 0);
    @(posedge clk);
    #1 chk("R3 stage1 one cycle later", int'(div8_o), 2);
    settle();
  endtask

  task automatic t_clear_gate();
    do_clear();
    pulse_a();
    pulse_b(); pulse_b(); pulse_b();
    @(negedge clk) clr_x = 1'b1;
    settle();
    chk("R4 x alone div2", int'(div2_o), 1);
    chk("R4 x alone div8", int'(div8_o), 3);
    @(negedge clk) begin clr_x = 1'b0; clr_y = 1'b1; end
    settle();
    chk("R4 y alone div2", int'(div2_o), 1);
    chk("R4 y alone div8", int'(div8_o), 3);
    @(negedge clk) clr_x = 1'b1;
    settle();
    chk("R4 both div2", int'(div2_o), 0);
    chk("R4 both div8", int'(div8_o), 0);
    @(negedge clk) begin clr_x = 1'b0; clr_y = 1'b0; end
    settle();
  endtask

  task automatic t_override_and_first();
    @(negedge clk) begin clr_x = 1'b1; clr_y = 1'b1; end
    settle();
    pulse_a();
    chk("R5 div2 held", int'(div2_o), 0);
    pulse_b();
    chk("R5 div8 held", int'(div8_o), 0);
    @(negedge clk) begin clr_x = 1'b0; clr_y = 1'b0; end
    settle();
    pulse_b();
    chk("R6 first B edge", int'(div8_o), 1);
    pulse_a();
    chk("R6 first A edge", int'(div2_o), 1);
  endtask

  task automatic t_cascade();
    int tog [0:3];
    logic [3:0] prev;
    do_clear();
    @(negedge clk) cascade = 1'b1;
    settle();
    for (int k = 0; k < 4; k++) tog[k] = 0;
    prev = 4'd0;
    for (int i = 1; i <= 32; i++) begin
      pulse_a();
      chk("R7 cascade value", int'({div8_o, div2_o}), i % 16);
      for (int k = 0; k < 4; k++)
        if ({div8_o, div2_o}[k] != prev[k]) tog[k]++;
      prev = {div8_o, div2_o};
    end
    for (int k = 0; k < 4; k++)
      chk("R7 toggles per bit", tog[k], 32 >> k);
    @(negedge clk) cascade = 1'b0;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_rise_ignored();
    t_div2();
    t_upper();
    t_ripple();
    t_clear_gate();
    t_override_and_first();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule